// File: doc/BRIEF.md
# Cascadable Decimal Counter Chain

This block is a multi-digit decimal counter built from identical four-bit digit stages that share one rising-edge clock. Each stage holds one digit and supports four operations, all synchronous: clear to zero, parallel load of a four-bit value, count up by one, and hold. An active-low clear has priority over an active-low load, and load has priority over counting. A stage counts only when both its parallel enable and its carry enable are high. Its terminal-count flag is high while the carry enable is high and the digit is 9. The parallel enable has no part in that flag, so the flag can feed the next stage's carry enable without waiting on it.

The wrapper chains `NUM_DIGITS` stages. One global parallel enable, clear and load drive every stage. The top-level count enable is the carry enable of the least significant stage. Each stage's terminal-count flag becomes the carry enable of the stage above it. The flag of the most significant stage is brought out as the chain's carry output, which can drive another chain.

Each stage is written around a small state machine. The state is the digit value, 0 to 15. Four transitions are named: CLEAR (to 0), LOAD (to the data input), COUNT (9 to 0, 15 to 0, otherwise plus one) and HOLD (unchanged). A priority decoder selects the transition for each edge.

Top module: `decade_chain`

## Requirements
- R1: When `clr_n` is low at a rising edge, every digit of `count` becomes 0 after that edge, whatever `load_n`, `cnt_en_par` and `cnt_en_carry` are.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, digit i of `count` (bits 4i+3..4i) takes the value of bits 4i+3..4i of `load_val`, whatever the two count enables are.
- R3: With `clr_n` and `load_n` high, the least significant digit advances by one at a rising edge when both `cnt_en_par` and `cnt_en_carry` are high. A digit at 9 goes to 0.
- R4: With `clr_n` and `load_n` high, a rising edge leaves `count` unchanged when `cnt_en_par` or `cnt_en_carry` is low.
- R5: `carry_out` is high exactly when `cnt_en_carry` is high and every digit equals 9. It does not depend on `cnt_en_par`, and it follows `cnt_en_carry` combinationally, without a clock edge.
- R6: A digit loaded with a value from 10 to 15 counts up in binary and goes from 15 to 0. While such a value is present, the terminal count of that digit stays low.
- R7: Digit i (i > 0) advances on a counting edge only when every lower digit is 9. A chain of all 9s goes to all 0s on one counting edge.
- R8: A clear or load applied together with both count enables high has the clear or load result. No increment is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_val | input | 4*NUM_DIGITS | Load data, digit i in bits 4i+3..4i |
| cnt_en_par | input | 1 | Parallel count enable, common to all stages |
| cnt_en_carry | input | 1 | Carry count enable of the least significant stage |
| count | output | 4*NUM_DIGITS | Counter value, digit i in bits 4i+3..4i |
| carry_out | output | 1 | Terminal count of the most significant stage |

## Verification
A wrong digit state shows on `count` one cycle after the edge that produced it. It also changes every later value, because the state carries forward through COUNT and HOLD. A wrong terminal count in a lower stage shows one edge later as an upper digit that moves when it should not, or stays when it should move. At the top stage the error shows at once on `carry_out`, because that path has no register. The bench compares every digit after every edge and `carry_out` before every edge against a per-digit reference model. Both random and directed stimulus reach all four transitions and the 10-to-15 values.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_TERM = 4'd9;
    localparam logic [DIGIT_W-1:0] DIGIT_ZERO = 4'd0;

    typedef enum logic [1:0] {
        TR_CLEAR = 2'd0,
        TR_LOAD  = 2'd1,
        TR_COUNT = 2'd2,
        TR_HOLD  = 2'd3
    } digit_tr_e;

endpackage

// File: rtl/decade_tr_sel.sv
module decade_tr_sel
    import decade_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_carry,
    output digit_tr_e tr
);

    always_comb begin
        if (!clr_n)
            tr = TR_CLEAR;
        else if (!load_n)
            tr = TR_LOAD;
        else if (en_par && en_carry)
            tr = TR_COUNT;
        else
            tr = TR_HOLD;
    end

endmodule

// File: rtl/decade_stage.sv
module decade_stage
    import decade_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] din,
    input  logic               en_par,
    input  logic               en_carry,
    output logic [DIGIT_W-1:0] digit,
    output logic               term
);

    digit_tr_e          tr;
    logic [DIGIT_W-1:0] digit_nxt;

    decade_tr_sel tr_sel_i (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .en_par   (en_par),
        .en_carry (en_carry),
        .tr       (tr)
    );

    // next-state selection: one arm per named transition
    always_comb begin
        unique case (tr)
            TR_CLEAR: digit_nxt = DIGIT_ZERO;
            TR_LOAD:  digit_nxt = din;
            TR_COUNT: digit_nxt = (digit == DIGIT_TERM) ? DIGIT_ZERO
                                                        : digit + 4'd1;
            TR_HOLD:  digit_nxt = digit;
            default:  digit_nxt = digit;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        digit <= digit_nxt;
    end

    // output process: terminal count gated only by the carry enable
    always_comb begin
        term = en_carry && (digit == DIGIT_TERM);
    end

    p_clear_r1: assert property (@(posedge clk)
        !clr_n |=> digit == DIGIT_ZERO);

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && !load_n) |=> digit == $past(din));

    p_count_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && load_n && en_par && en_carry) |=>
            digit == (($past(digit) == DIGIT_TERM) ? DIGIT_ZERO
                                                   : $past(digit) + 4'd1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (clr_n && load_n && !(en_par && en_carry)) |=> $stable(digit));

    p_no_term_high_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (digit > DIGIT_TERM) |-> !term);

    p_term_needs_carry_r5: assert property (@(posedge clk) disable iff (!clr_n)
        term |-> en_carry);

endmodule

// File: rtl/decade_chain.sv
module decade_chain
    import decade_pkg::*;
#(
    parameter int NUM_DIGITS = 3
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          load_n,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] load_val,
    input  logic                          cnt_en_par,
    input  logic                          cnt_en_carry,
    output logic [NUM_DIGITS*DIGIT_W-1:0] count,
    output logic                          carry_out
);

    localparam int CW = NUM_DIGITS + 1;

    logic [CW-1:0] carry;

    assign carry[0]  = cnt_en_carry;
    assign carry_out = carry[NUM_DIGITS];

    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_stage
        decade_stage stage_i (
            .clk      (clk),
            .clr_n    (clr_n),
            .load_n   (load_n),
            .din      (load_val[gi*DIGIT_W +: DIGIT_W]),
            .en_par   (cnt_en_par),
            .en_carry (carry[gi]),
            .digit    (count[gi*DIGIT_W +: DIGIT_W]),
            .term     (carry[gi+1])
        );

        if (gi > 0) begin : g_chk
            // upper digit stays put unless the stage below hands it a carry
            p_chain_hold_r7: assert property (@(posedge clk) disable iff (!clr_n)
                (clr_n && load_n && !carry[gi]) |=>
                    $stable(count[gi*DIGIT_W +: DIGIT_W]));
        end
    end

endmodule

// File: tb/decade_chain_tb.sv
module decade_chain_tb_top;

    localparam int N = 3;
    localparam int W = 4 * N;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic [W-1:0] load_val = '0;
    logic         cnt_en_par = 1'b0;
    logic         cnt_en_carry = 1'b0;
    logic [W-1:0] count;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [N];

    always #5ns clk = ~clk;

    decade_chain #(.NUM_DIGITS(N)) dut_i (
        .clk          (clk),
        .clr_n        (clr_n),
        .load_n       (load_n),
        .load_val     (load_val),
        .cnt_en_par   (cnt_en_par),
        .cnt_en_carry (cnt_en_carry),
        .count        (count),
        .carry_out    (carry_out)
    );

    function automatic logic [W-1:0] pack_model();
        logic [W-1:0] v;
        for (int i = 0; i < N; i++) v[i*4 +: 4] = model[i];
        return v;
    endfunction

    function automatic logic exp_carry(input logic cet);
        logic c;
        c = cet;
        for (int i = 0; i < N; i++) c = c && (model[i] == 4'd9);
        return c;
    endfunction

    function automatic logic [W-1:0] dec3(input int v);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic update_model(input logic c, input logic l, input logic [W-1:0] d,
                                input logic p, input logic t);
        logic cy;
        logic [3:0] old;
        cy = t;
        for (int i = 0; i < N; i++) begin
            old = model[i];
            if (!c)              model[i] = 4'd0;
            else if (!l)         model[i] = d[i*4 +: 4];
            else if (p && cy)    model[i] = (old == 4'd9) ? 4'd0 : old + 4'd1;
            cy = cy && (old == 4'd9);
        end
    endtask

    task automatic cycle(input string req, input logic c, input logic l,
                         input logic [W-1:0] d, input logic p, input logic t);
        @(negedge clk);
        clr_n = c; load_n = l; load_val = d; cnt_en_par = p; cnt_en_carry = t;
        #1ns;
        chk({req, "/R5 carry_out"}, W'(carry_out), W'(exp_carry(t)));
        @(posedge clk);
        update_model(c, l, d, p, t);
        #1ns;
        chk({req, " count"}, count, pack_model());
    endtask

    initial begin : watchdog
        #2ms;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] rv;
        void'($urandom(32'h5EED_0162));
        for (int i = 0; i < N; i++) model[i] = 4'd0;

        // R1 reset state, clear wins over load and enables
        repeat (2) cycle("R1", 1'b0, 1'b0, dec3(555), 1'b1, 1'b1);
        chk("R1 reset", count, '0);

        // R2 load, R8 load beats counting
        cycle("R2", 1'b1, 1'b0, dec3(998), 1'b1, 1'b1);
        chk("R8 load over count", count, dec3(998));
        // R3 count to 999, R5 carry visible, R7 rollover
        cycle("R3", 1'b1, 1'b1, '0, 1'b1, 1'b1);
        chk("R3 998->999", count, dec3(999));
        @(negedge clk);
        cnt_en_par = 1'b0; cnt_en_carry = 1'b1; #1ns;
        chk("R5 carry with par low", W'(carry_out), W'(1));
        cnt_en_carry = 1'b0; #1ns;
        chk("R5 carry follows enable", W'(carry_out), W'(0));
        cycle("R4", 1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R4 hold par low", count, dec3(999));
        cycle("R4", 1'b1, 1'b1, '0, 1'b1, 1'b0);
        chk("R4 hold carry low", count, dec3(999));
        cycle("R7", 1'b1, 1'b1, '0, 1'b1, 1'b1);
        chk("R7 999->000", count, dec3(0));

        // R8 clear over load with enables
        cycle("R8", 1'b1, 1'b0, dec3(321), 1'b0, 1'b0);
        cycle("R8", 1'b0, 1'b0, dec3(777), 1'b1, 1'b1);
        chk("R8 clear over load", count, '0);

        // R6 out-of-range digit: 13,14,15,0 with no carry
        cycle("R6", 1'b1, 1'b0, {4'd9, 4'd0, 4'd13}, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) cycle("R6", 1'b1, 1'b1, '0, 1'b1, 1'b1);
        chk("R6 15->0", count, {4'd9, 4'd0, 4'd0});
        cycle("R6", 1'b1, 1'b0, {4'd12, 4'd9, 4'd9}, 1'b0, 1'b0);
        cycle("R6", 1'b1, 1'b1, '0, 1'b1, 1'b1);
        chk("R6 upper binary step", count, {4'd13, 4'd0, 4'd0});

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            rv = W'($urandom);
            if ($urandom_range(3) == 0) rv = dec3(int'($urandom_range(999)));
            cycle("RND R3/R7", $urandom_range(49) != 0, $urandom_range(19) != 0,
                  rv, $urandom_range(7) != 0, $urandom_range(7) != 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule